// File: doc/BRIEF.md
# CAN Pin Test-Mode Router with Bus Wake

This block sits between a CAN protocol engine and the two external bus pins. The engine is represented here by a transmit bit coming in and a receive bit going out. Three test controls steer those bits. The receive path can follow the pin, freeze at its last value, or take the engine's own transmit bit as an internal loopback. The transmit pin can follow the engine or freeze at its last value. Freezing keeps the most recent level; it does not force the line recessive.

The block also keeps a sleep flag. Software sets and clears it through the register port. When automatic wake is enabled, a dominant level seen on the receive pin clears the flag without software. The receive pin goes through a reset-to-recessive synchronizer before anything uses it, and that includes wake detection. A dominant level is logic 0 and recessive is logic 1.

The control word is written with `reg_wr`/`reg_wdata` and is always visible on `reg_rdata`.

Top module: `can_pin_test_ctrl`

## Requirements
- R1: After a synchronous reset, `reg_rdata` is 0 and both held levels and all synchronizer stages are recessive (1). With `pin_rx` low, `eng_rx` is therefore 1 until the synchronizer fills.
- R2: A write stores bit 10 as rx-freeze, bit 9 as tx-freeze, bit 8 as loopback and bit 7 as wake-enable. Bit 0 is the sleep flag. All other bits, reserved bit 6 among them, read as 0 and store nothing.
- R3: With loopback 0 and rx-freeze 0, `eng_rx` equals `pin_rx` as it was two clock edges earlier.
- R4: With loopback 0 and rx-freeze 1, `eng_rx` stays at the synchronized pin value from the clock edge on which rx-freeze was written, whatever the pin does.
- R5: With loopback 1, `eng_rx` equals `eng_tx` in the same cycle, whatever rx-freeze holds.
- R6: With tx-freeze 0, `pin_tx` equals `eng_tx` in the same cycle.
- R7: With tx-freeze 1, `pin_tx` stays at the `eng_tx` value that was present at the clock edge that set tx-freeze, whatever the loopback setting.
- R8: A write sets the sleep flag to `reg_wdata[0]`. With wake-enable 0, a dominant receive level never changes the flag.
- R9: With wake-enable 1 and sleep 1, a synchronized dominant pin level clears sleep on the next edge. This clear wins over a write of 1 to sleep in that same cycle.
- R10: Wake detection always uses the synchronized external pin, including when rx-freeze or loopback changes what `eng_rx` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read-back |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| eng_rx | output | 1 | Receive bit to the protocol engine |
| pin_rx | input | 1 | External receive pin |
| pin_tx | output | 1 | External transmit pin |
| sleep_flag | output | 1 | Current sleep state |

## Verification
The hardest case to reach is a write of sleep=1 that lands on the same edge as a synchronized dominant level while wake is enabled. The dominant level shows up only two edges after the pin falls. To hit that edge, the stimulus holds the pin recessive while it sets sleep and wake, then drops the pin and issues writes of 1 on every following cycle. A second run repeats this with loopback and rx-freeze active, so that `eng_rx` does not show the pin the wake logic is reading.

// File: rtl/can_pin_pkg.sv
package can_pin_pkg;

    localparam int CTRL_W    = 16;
    localparam int POS_RXOFF = 10;
    localparam int POS_TXOFF = 9;
    localparam int POS_LOOP  = 8;
    localparam int POS_WAKE  = 7;
    localparam int POS_SLEEP = 0;

    localparam logic LVL_RECESSIVE = 1'b1;
    localparam logic LVL_DOMINANT  = 1'b0;

    typedef struct packed {
        logic rx_off;
        logic tx_off;
        logic loop_en;
        logic wake_en;
    } test_ctrl_t;

    localparam test_ctrl_t CTRL_RESET = '{rx_off: 1'b0, tx_off: 1'b0, loop_en: 1'b0, wake_en: 1'b0};

    function automatic test_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        test_ctrl_t c;
        c.rx_off  = w[POS_RXOFF];
        c.tx_off  = w[POS_TXOFF];
        c.loop_en = w[POS_LOOP];
        c.wake_en = w[POS_WAKE];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] encode_ctrl(input test_ctrl_t c, input logic slp);
        logic [CTRL_W-1:0] w;
        w            = '0;
        w[POS_RXOFF] = c.rx_off;
        w[POS_TXOFF] = c.tx_off;
        w[POS_LOOP]  = c.loop_en;
        w[POS_WAKE]  = c.wake_en;
        w[POS_SLEEP] = slp;
        return w;
    endfunction

endpackage

// File: rtl/can_pin_sync.sv
module can_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    import can_pin_pkg::*;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{LVL_RECESSIVE}};
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/can_pin_regs.sv
module can_pin_regs (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [can_pin_pkg::CTRL_W-1:0] wdata,
    input  logic                          rx_sync,
    output can_pin_pkg::test_ctrl_t       ctrl,
    output logic                          sleep,
    output logic [can_pin_pkg::CTRL_W-1:0] rdata
);
    import can_pin_pkg::*;

    logic wake_hit;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[CTRL_W-1:POS_RXOFF+1], wdata[POS_WAKE-1:POS_SLEEP+1]};
    assign wake_hit     = sleep && ctrl.wake_en && (rx_sync == LVL_DOMINANT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            sleep <= 1'b0;
        end else begin
            if (wr) ctrl <= decode_ctrl(wdata);
            if (wake_hit)  sleep <= 1'b0;
            else if (wr)   sleep <= wdata[POS_SLEEP];
        end
    end

    assign rdata = encode_ctrl(ctrl, sleep);

    // R9: synchronized dominant with wake enabled always ends sleep
    assert_wake_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (sleep && ctrl.wake_en && rx_sync == LVL_DOMINANT) |=> !sleep);

    // R8: without wake enabled, only a write moves the sleep flag
    assert_sleep_write_only_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wake_en && !wr) |=> $stable(sleep));

    // R2: control fields move only on a write
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl));
endmodule

// File: rtl/can_pin_route.sv
module can_pin_route (
    input  logic                    clk,
    input  logic                    rst,
    input  can_pin_pkg::test_ctrl_t ctrl,
    input  logic                    rx_sync,
    input  logic                    eng_tx,
    output logic                    eng_rx,
    output logic                    pin_tx
);
    import can_pin_pkg::*;

    logic rx_hold;
    logic tx_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold <= LVL_RECESSIVE;
            tx_hold <= LVL_RECESSIVE;
        end else begin
            if (!ctrl.rx_off) rx_hold <= rx_sync;
            if (!ctrl.tx_off) tx_hold <= eng_tx;
        end
    end

    always_comb begin
        if (ctrl.loop_en)     eng_rx = eng_tx;
        else if (ctrl.rx_off) eng_rx = rx_hold;
        else                  eng_rx = rx_sync;
    end

    assign pin_tx = ctrl.tx_off ? tx_hold : eng_tx;

    // R4: frozen receive path does not move while loopback stays off
    assert_rx_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.rx_off && !ctrl.loop_en && $past(ctrl.rx_off) && !$past(ctrl.loop_en)) |-> $stable(eng_rx));

    // R7: frozen transmit pin does not move
    assert_tx_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tx_off && $past(ctrl.tx_off)) |-> $stable(pin_tx));
endmodule

// File: rtl/can_pin_test_ctrl.sv
module can_pin_test_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        eng_tx,
    output logic        eng_rx,
    input  logic        pin_rx,
    output logic        pin_tx,
    output logic        sleep_flag
);
    import can_pin_pkg::*;

    logic       rx_sync;
    test_ctrl_t ctrl;

    can_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_rx),
        .sync_out (rx_sync)
    );

    can_pin_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rx_sync (rx_sync),
        .ctrl    (ctrl),
        .sleep   (sleep_flag),
        .rdata   (reg_rdata)
    );

    can_pin_route u_route (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .rx_sync (rx_sync),
        .eng_tx  (eng_tx),
        .eng_rx  (eng_rx),
        .pin_tx  (pin_tx)
    );

    // R5: loopback ties the engine's receive bit to its own transmit bit
    assert_loopback_R5: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[POS_LOOP] |-> (eng_rx == eng_tx));

    // R6: transmit pin follows the engine when not frozen
    assert_tx_follow_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[POS_TXOFF] |-> (pin_tx == eng_tx));
endmodule

// File: tb/can_pin_test_ctrl_bench.sv
module can_pin_test_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        eng_tx;
    logic        eng_rx;
    logic        pin_rx;
    logic        pin_tx;
    logic        sleep_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_pin_test_ctrl u_can_pin_test_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .eng_tx(eng_tx), .eng_rx(eng_rx),
        .pin_rx(pin_rx), .pin_tx(pin_tx), .sleep_flag(sleep_flag)
    );

    // behavioural reference state
    bit m_rxoff, m_txoff, m_loop, m_wake, m_sleep;
    bit m_rxh, m_txh;
    bit syncq[$];

    always @(posedge clk) begin
        bit wake, s_out;
        if (rst) begin
            {m_rxoff, m_txoff, m_loop, m_wake, m_sleep} = '0;
            m_rxh = 1; m_txh = 1;
            syncq = '{1, 1};
        end else begin
            s_out = syncq[1];
            wake  = m_sleep && m_wake && (s_out == 0);
            if (!m_rxoff) m_rxh = s_out;
            if (!m_txoff) m_txh = eng_tx;
            if (wake) m_sleep = 0;
            else if (reg_wr) m_sleep = reg_wdata[0];
            if (reg_wr) begin
                m_rxoff = reg_wdata[10]; m_txoff = reg_wdata[9];
                m_loop  = reg_wdata[8];  m_wake  = reg_wdata[7];
            end
            syncq.push_front(pin_rx);
            void'(syncq.pop_back());
        end
    end

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_rx, exp_tx;
        logic [15:0] exp_rd;
        string rtag, ttag, stag;
        exp_rx = m_loop ? eng_tx : (m_rxoff ? m_rxh : syncq[1]);
        exp_tx = m_txoff ? m_txh : eng_tx;
        exp_rd = 16'h0;
        exp_rd[10] = m_rxoff; exp_rd[9] = m_txoff; exp_rd[8] = m_loop;
        exp_rd[7] = m_wake; exp_rd[0] = m_sleep;
        rtag = m_loop ? "R5" : (m_rxoff ? "R4" : "R3");
        ttag = m_txoff ? "R7" : "R6";
        stag = !m_wake ? "R8" : ((m_loop || m_rxoff) ? "R10" : "R9");
        chk("R2", "reg_rdata", reg_rdata, exp_rd);
        chk(rtag, "eng_rx", {15'b0, eng_rx}, {15'b0, exp_rx});
        chk(ttag, "pin_tx", {15'b0, pin_tx}, {15'b0, exp_tx});
        chk(stag, "sleep_flag", {15'b0, sleep_flag}, {15'b0, m_sleep});
    endtask

    // one cycle: check at the falling edge, then apply next inputs
    task automatic step(bit wr, logic [15:0] wd, bit prx, bit etx);
        @(negedge clk);
        compare_all();
        reg_wr = wr; reg_wdata = wd; pin_rx = prx; eng_tx = etx;
    endtask

    task automatic idle_rand(int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 1'($urandom), 1'($urandom));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_wr = 0; reg_wdata = 0; pin_rx = 0; eng_tx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, synchronizer still recessive although pin is low
        chk("R1", "reset rdata", reg_rdata, 16'h0);
        chk("R1", "reset eng_rx", {15'b0, eng_rx}, 16'h1);
        chk("R1", "reset sleep", {15'b0, sleep_flag}, 16'h0);
        rst = 0;
        @(negedge clk);
        chk("R1", "eng_rx first cycle", {15'b0, eng_rx}, 16'h1);
        // R3/R6 normal pass-through
        idle_rand(40);
        // R2: reserved and unused bits ignored
        step(1, 16'hF87E, 1, 0);
        step(0, 16'h0, 1, 0);
        step(1, 16'h0000, 0, 1);
        // R4: rx freeze with toggling pin
        step(1, 16'h0400, 0, 1);
        idle_rand(30);
        // R7: tx freeze
        step(1, 16'h0200, 1, 1);
        idle_rand(30);
        step(1, 16'h0600, 1, 0);
        idle_rand(20);
        // R5: loopback alone and with both freezes
        step(1, 16'h0100, 0, 0);
        idle_rand(20);
        step(1, 16'h0700, 1, 1);
        idle_rand(20);
        step(1, 16'h0300, 0, 1);
        idle_rand(20);
        // R8: sleep with wake disabled, pin dominant
        step(1, 16'h0001, 0, 1);
        idle_rand(10);
        for (int i = 0; i < 10; i++) step(0, 16'h0, 0, 1);
        step(1, 16'h0000, 1, 1);
        step(1, 16'h0001, 1, 1);
        // R9: wake enabled, pin goes dominant while writes of 1 keep coming
        step(1, 16'h0081, 1, 1);
        step(0, 16'h0, 1, 1);
        step(0, 16'h0, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 16'h0081, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 16'h0, 1, 1);
        // R10: same with loopback and rx freeze
        step(1, 16'h0781, 1, 0);
        step(0, 16'h0, 1, 0);
        step(0, 16'h0, 1, 0);
        for (int i = 0; i < 6; i++) step(1, 16'h0781, 0, 1);
        idle_rand(5);
        // random soak
        for (int i = 0; i < 3000; i++) begin
            bit w;
            w = ($urandom % 8) == 0;
            step(w, 16'($urandom), 1'(($urandom % 4) != 0), 1'($urandom));
        end
        // mid-run reset returns to R1 state
        @(negedge clk); rst = 1; reg_wr = 0;
        @(negedge clk);
        chk("R1", "rdata after reset", reg_rdata, 16'h0);
        rst = 0;
        idle_rand(10);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule